// File: doc/BRIEF.md
# Integer Register Bank with Byte Aliases and Condition Flags

This block holds the integer state of a small processor core: eight 32-bit general registers and four one-bit condition flags (sign, zero, carry, overflow). Two independent read ports return full registers combinationally, and one write port loads a full register on the rising clock edge. Registers are numbered 0 to 7; the register at index 4 is the one that software uses as the stack pointer, but the bank itself treats all eight alike for full-width access.

A separate byte path gives 8-bit read and write access to the two low bytes of registers 0 to 3 only. A 3-bit byte index picks the byte. Indices 0 to 3 name bits 7:0 of registers 0 to 3, and indices 4 to 7 name bits 15:8 of registers 0 to 3. A byte write merges into the register and leaves its other 24 bits untouched. Registers 4 to 7 have no byte path at all. The flags are loaded together from four inputs when a load enable is high and keep their value otherwise. A synchronous, active-high reset clears every register and every flag.

Top module: `gpr_bank`

## Requirements
- R1: While `rst` is high at a rising edge, every register and all four flags become 0 after that edge.
- R2: With `wr_en` high, `wr_data` lands in register `wr_idx` at the rising edge. Both read ports return register contents combinationally, and a read of the register being written in that cycle returns the old value.
- R3: Byte indices 0, 1, 2 and 3 read bits 7:0 of registers 0, 1, 2 and 3 respectively. Example: register 3 = 0x11223344 gives 0x44 at byte index 3.
- R4: Byte indices 4, 5, 6 and 7 read bits 15:8 of registers 0, 1, 2 and 3 respectively. Example: register 3 = 0x11223344 gives 0x33 at byte index 7.
- R5: A byte write (`bwr_en` high) replaces only the 8 bits that its index selects (mapping of R3/R4); the other 24 bits of that register keep their value.
- R6: In one cycle a full write and a byte write to different registers both take effect. The same register targeted by both in one cycle is not a legal input.
- R7: With `flag_we` high, the flag outputs take `sf_in`, `zf_in`, `cf_in`, `of_in` at the rising edge. With `flag_we` low, they hold.
- R8: Registers 4 to 7 are never changed by any byte write.
- R9: With `wr_en` and `bwr_en` low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 3 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 3 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Full-width write enable |
| wr_idx | input | 3 | Full-width write register index |
| wr_data | input | 32 | Full-width write data |
| brd_idx | input | 3 | Byte read index (0-3 low byte, 4-7 second byte of registers 0-3) |
| brd_data | output | 8 | Byte read data |
| bwr_en | input | 1 | Byte write enable |
| bwr_idx | input | 3 | Byte write index, same mapping as `brd_idx` |
| bwr_data | input | 8 | Byte write data |
| flag_we | input | 1 | Flag load enable |
| sf_in | input | 1 | Sign flag load value |
| zf_in | input | 1 | Zero flag load value |
| cf_in | input | 1 | Carry flag load value |
| of_in | input | 1 | Overflow flag load value |
| sf | output | 1 | Sign flag |
| zf | output | 1 | Zero flag |
| cf | output | 1 | Carry flag |
| of | output | 1 | Overflow flag |

## Verification
The full-width write and the byte write can land in the same cycle, and the bench provokes this by driving both enables in one cycle toward different registers, one of them a second-byte alias (byte index 6 onto register 2 while register 6 is written whole). It judges the outcome by reading both registers afterwards through the full-width ports: each must show exactly its own update, with the merged register's untouched bytes intact. The same cycle also checks read-during-write, where the read port must still show the pre-edge value of the register being written.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    typedef struct packed {
        logic sign;
        logic zero;
        logic carry;
        logic ovf;
    } cond_flags_t;

endpackage

// File: rtl/gpr_byte_map.sv
// Turns a byte-path index into the register that owns the byte and the
// byte lane inside that register.
module gpr_byte_map #(
    parameter int IDX_W  = 3,
    parameter int NBREG  = 4,
    parameter int LANE_W = 2
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [LANE_W-1:0] lane
);

    always_comb begin
        if (idx < IDX_W'(NBREG)) begin
            reg_idx = idx;
            lane    = '0;
        end else begin
            reg_idx = idx - IDX_W'(NBREG);
            lane    = LANE_W'(1);
        end
    end

    // the target must always be one of the byte-addressable registers (R8)
    always_comb begin
        assert_target_low_R8: assert (reg_idx < IDX_W'(NBREG) || $isunknown(idx));
    end

endmodule

// File: rtl/gpr_byte_merge.sv
// Replaces one byte lane of a word, passing the other lanes through.
module gpr_byte_merge #(
    parameter int XLEN   = 32,
    parameter int BYTE_W = 8,
    parameter int LANE_W = 2
) (
    input  logic [XLEN-1:0]   word_in,
    input  logic [BYTE_W-1:0] bval,
    input  logic [LANE_W-1:0] lane,
    output logic [XLEN-1:0]   word_out
);

    localparam int LANES = XLEN / BYTE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word_out[g*BYTE_W +: BYTE_W] =
            (lane == LANE_W'(g)) ? bval : word_in[g*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
    import gpr_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NREG   = 8,
    parameter int BYTE_W = 8,
    parameter int NBREG  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [$clog2(NREG)-1:0]   rd_a_idx,
    output logic [XLEN-1:0]           rd_a_data,
    input  logic [$clog2(NREG)-1:0]   rd_b_idx,
    output logic [XLEN-1:0]           rd_b_data,
    input  logic                      wr_en,
    input  logic [$clog2(NREG)-1:0]   wr_idx,
    input  logic [XLEN-1:0]           wr_data,
    input  logic [$clog2(NREG)-1:0]   brd_idx,
    output logic [BYTE_W-1:0]         brd_data,
    input  logic                      bwr_en,
    input  logic [$clog2(NREG)-1:0]   bwr_idx,
    input  logic [BYTE_W-1:0]         bwr_data,
    input  logic                      flag_we,
    input  logic                      sf_in,
    input  logic                      zf_in,
    input  logic                      cf_in,
    input  logic                      of_in,
    output logic                      sf,
    output logic                      zf,
    output logic                      cf,
    output logic                      of
);

    localparam int IDX_W  = $clog2(NREG);
    localparam int LANES  = XLEN / BYTE_W;
    localparam int LANE_W = $clog2(LANES);

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] regs;
        cond_flags_t               flags;
    } bank_state_t;

    bank_state_t state_d, state_q;

    logic [IDX_W-1:0]  bwr_reg, brd_reg;
    logic [LANE_W-1:0] bwr_lane, brd_lane;
    logic [XLEN-1:0]   bwr_merged;
    logic [XLEN-1:0]   brd_word;

    gpr_byte_map #(.IDX_W(IDX_W), .NBREG(NBREG), .LANE_W(LANE_W)) u_wmap (
        .idx     (bwr_idx),
        .reg_idx (bwr_reg),
        .lane    (bwr_lane)
    );

    gpr_byte_map #(.IDX_W(IDX_W), .NBREG(NBREG), .LANE_W(LANE_W)) u_rmap (
        .idx     (brd_idx),
        .reg_idx (brd_reg),
        .lane    (brd_lane)
    );

    gpr_byte_merge #(.XLEN(XLEN), .BYTE_W(BYTE_W), .LANE_W(LANE_W)) u_merge (
        .word_in  (state_q.regs[bwr_reg]),
        .bval     (bwr_data),
        .lane     (bwr_lane),
        .word_out (bwr_merged)
    );

    // next-state computation
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.regs[wr_idx] = wr_data;
        end
        if (bwr_en) begin
            state_d.regs[bwr_reg] = bwr_merged;
        end
        if (flag_we) begin
            state_d.flags = '{sign: sf_in, zero: zf_in, carry: cf_in, ovf: of_in};
        end
        if (rst) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // combinational reads
    assign rd_a_data = state_q.regs[rd_a_idx];
    assign rd_b_data = state_q.regs[rd_b_idx];
    assign brd_word  = state_q.regs[brd_reg];

    always_comb begin
        brd_data = '0;
        for (int k = 0; k < LANES; k++) begin
            if (brd_lane == LANE_W'(k)) begin
                brd_data = brd_word[k*BYTE_W +: BYTE_W];
            end
        end
    end

    assign sf = state_q.flags.sign;
    assign zf = state_q.flags.zero;
    assign cf = state_q.flags.carry;
    assign of = state_q.flags.ovf;

    // ---------------- assertions ----------------
    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_a_data == '0 && rd_b_data == '0 && {sf, zf, cf, of} == 4'b0));

    assert_word_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !(bwr_en && bwr_reg == wr_idx))
        |=> state_q.regs[$past(wr_idx)] == $past(wr_data));

    assert_byte_upper_kept_R5: assert property (@(posedge clk) disable iff (rst)
        (bwr_en && !(wr_en && wr_idx == bwr_reg))
        |=> state_q.regs[$past(bwr_reg)][XLEN-1:2*BYTE_W]
            == $past(state_q.regs[bwr_reg][XLEN-1:2*BYTE_W]));

    assert_flag_load_R7: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> {sf, zf, cf, of} == $past({sf_in, zf_in, cf_in, of_in}));

    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable({sf, zf, cf, of}));

    assert_upper_regs_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(state_q.regs[NREG-1:NBREG]));

    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !bwr_en) |=> $stable(state_q.regs));

endmodule

// File: tb/gpr_bank_test.sv
`timescale 1ns/1ps
module gpr_bank_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  rd_a_idx, rd_b_idx, wr_idx, brd_idx, bwr_idx;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic        wr_en, bwr_en, flag_we;
    logic [7:0]  brd_data, bwr_data;
    logic        sf_in, zf_in, cf_in, of_in, sf, zf, cf, of;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    gpr_bank uut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .brd_idx(brd_idx), .brd_data(brd_data),
        .bwr_en(bwr_en), .bwr_idx(bwr_idx), .bwr_data(bwr_data),
        .flag_we(flag_we), .sf_in(sf_in), .zf_in(zf_in), .cf_in(cf_in), .of_in(of_in),
        .sf(sf), .zf(zf), .cf(cf), .of(of)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic rd_word(input logic [2:0] idx, output logic [31:0] v);
        rd_a_idx = idx;
        #1;
        v = rd_a_data;
    endtask

    task automatic rd_byte(input logic [2:0] idx, output logic [7:0] v);
        brd_idx = idx;
        #1;
        v = brd_data;
    endtask

    task automatic put_word(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic put_byte(input logic [2:0] idx, input logic [7:0] d);
        @(negedge clk);
        bwr_en = 1'b1; bwr_idx = idx; bwr_data = d;
        @(negedge clk);
        bwr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset(string tag);
        logic [31:0] v;
        do_reset();
        for (int i = 0; i < 8; i++) begin
            rd_word(3'(i), v);
            check({"R1 reg zero ", tag}, v, 32'h0);
        end
        check({"R1 flags zero ", tag}, {28'h0, sf, zf, cf, of}, 32'h0);
    endtask

    task automatic t_word_rw();
        logic [31:0] v;
        for (int i = 0; i < 8; i++) put_word(3'(i), 32'h1000_0001 * (i + 1));
        for (int i = 0; i < 8; i++) begin
            rd_word(3'(i), v);
            check("R2 word readback port A", v, 32'h1000_0001 * (i + 1));
            rd_b_idx = 3'(7 - i);
            #1;
            check("R2 word readback port B", rd_b_data, 32'h1000_0001 * (8 - i));
        end
        // read during write returns the old value
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd5; wr_data = 32'hDEAD_BEEF; rd_a_idx = 3'd5;
        #1;
        check("R2 read during write old", rd_a_data, 32'h1000_0001 * 6);
        @(negedge clk);
        wr_en = 1'b0;
        rd_word(3'd5, v);
        check("R2 read after write new", v, 32'hDEAD_BEEF);
    endtask

    task automatic t_byte_map();
        logic [7:0] b;
        put_word(3'd0, 32'hA0A1_A2A3);
        put_word(3'd1, 32'hB0B1_B2B3);
        put_word(3'd2, 32'hC0C1_C2C3);
        put_word(3'd3, 32'h1122_3344);
        rd_byte(3'd3, b); check("R3 idx3 low byte", {24'h0, b}, 32'h44);
        rd_byte(3'd7, b); check("R4 idx7 second byte", {24'h0, b}, 32'h33);
        rd_byte(3'd0, b); check("R3 idx0", {24'h0, b}, 32'hA3);
        rd_byte(3'd1, b); check("R3 idx1", {24'h0, b}, 32'hB3);
        rd_byte(3'd2, b); check("R3 idx2", {24'h0, b}, 32'hC3);
        rd_byte(3'd4, b); check("R4 idx4", {24'h0, b}, 32'hA2);
        rd_byte(3'd5, b); check("R4 idx5", {24'h0, b}, 32'hB2);
        rd_byte(3'd6, b); check("R4 idx6", {24'h0, b}, 32'hC2);
    endtask

    task automatic t_byte_merge();
        logic [31:0] v;
        logic [7:0]  b;
        put_word(3'd1, 32'hA5A5_A5A5);
        put_byte(3'd1, 8'h3C);
        rd_word(3'd1, v); check("R5 low byte merge", v, 32'hA5A5_A53C);
        put_byte(3'd5, 8'hC3);
        rd_word(3'd1, v); check("R5 second byte merge", v, 32'hA5A5_C33C);
        rd_byte(3'd5, b); check("R4 byte read after merge", {24'h0, b}, 32'hC3);
        rd_word(3'd0, v); check("R5 neighbour untouched", v, 32'hA0A1_A2A3);
    endtask

    task automatic t_upper_no_byte();
        logic [31:0] v;
        for (int i = 4; i < 8; i++) put_word(3'(i), 32'h5500_0000 + i);
        for (int i = 0; i < 8; i++) put_byte(3'(i), 8'hFF);
        for (int i = 4; i < 8; i++) begin
            rd_word(3'(i), v);
            check("R8 upper reg unchanged by byte writes", v, 32'h5500_0000 + i);
        end
        rd_word(3'd3, v); check("R8 byte writes landed in reg3", v, 32'h1122_FFFF);
    endtask

    task automatic t_dual_write();
        logic [31:0] v;
        put_word(3'd2, 32'h7777_7777);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd6; wr_data = 32'h6666_0006;
        bwr_en = 1'b1; bwr_idx = 3'd6; bwr_data = 8'h99;
        rd_a_idx = 3'd6;
        #1;
        check("R2 same-cycle read old reg6", rd_a_data, 32'h5500_0006);
        @(negedge clk);
        wr_en = 1'b0; bwr_en = 1'b0;
        rd_word(3'd6, v); check("R6 word write landed", v, 32'h6666_0006);
        rd_word(3'd2, v); check("R6 byte write landed", v, 32'h7777_9977);
    endtask

    task automatic t_idle();
        logic [31:0] v;
        @(negedge clk);
        wr_en = 1'b0; wr_idx = 3'd2; wr_data = 32'h0BAD_0BAD;
        bwr_en = 1'b0; bwr_idx = 3'd2; bwr_data = 8'h00;
        repeat (3) @(negedge clk);
        rd_word(3'd2, v); check("R9 disabled writes ignored", v, 32'h7777_9977);
        rd_word(3'd6, v); check("R9 other reg intact", v, 32'h6666_0006);
    endtask

    task automatic t_flags();
        @(negedge clk);
        flag_we = 1'b1; {sf_in, zf_in, cf_in, of_in} = 4'b1010;
        @(negedge clk);
        flag_we = 1'b0; {sf_in, zf_in, cf_in, of_in} = 4'b0101;
        #1;
        check("R7 flags loaded 1010", {28'h0, sf, zf, cf, of}, 32'hA);
        repeat (2) @(negedge clk);
        check("R7 flags held", {28'h0, sf, zf, cf, of}, 32'hA);
        flag_we = 1'b1; {sf_in, zf_in, cf_in, of_in} = 4'b0111;
        @(negedge clk);
        flag_we = 1'b0;
        check("R7 flags loaded 0111", {28'h0, sf, zf, cf, of}, 32'h7);
    endtask

    initial begin
        rst = 1'b1;
        wr_en = 0; bwr_en = 0; flag_we = 0;
        wr_idx = 0; wr_data = 0; bwr_idx = 0; bwr_data = 0;
        rd_a_idx = 0; rd_b_idx = 0; brd_idx = 0;
        {sf_in, zf_in, cf_in, of_in} = 4'b0;
        repeat (2) @(negedge clk);
        t_reset("start");
        t_word_rw();
        t_byte_map();
        t_byte_merge();
        t_upper_no_byte();
        t_dual_write();
        t_idle();
        t_flags();
        t_reset("end");
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1..all actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule